// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block is a 32-bit general purpose I/O port with a direction bit, an output level and a synchronized input sample for each bit. Any bit that is set as an input can latch a rising edge, a falling edge or both into a sticky status bit. The interrupt line goes high while any status bit is set.

Software controls the block through a simple word-wide register port. A write takes effect on the clock edge where `regWrEn` is high. Read data follows `regAddr` combinationally. The output register and both edge-enable registers each have a pair of write-only alias addresses, one that sets bits and one that clears bits. In an alias write, a 1 changes its bit and a 0 leaves its bit as it was, so one bit can change without a read-modify-write.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every bit is an input (`pinDirOut` = 0). The output register, both enable registers, the status register and `irqOut` are all 0.
- R2: Writing the direction register (address 0) drives `pinDirOut`, where 1 means output. Writing the output register (address 1) drives `pinOut`. Both registers read back at their own address.
- R3: Address 2 sets each output bit written as 1. Address 3 clears each output bit written as 1. Bits written as 0 keep their value.
- R4: Address 4 reads the input pins through a two-flop synchronizer. A pin held steady is readable two clock edges after it changes.
- R5: The rising enable register is at address 5, with a bit-set alias at address 6 and a bit-clear alias at address 7. Alias bits written as 0 are left unchanged.
- R6: The falling enable register is at address 8, with a bit-set alias at address 9 and a bit-clear alias at address 10. Alias bits written as 0 are left unchanged.
- R7: On an input bit, a 0-to-1 change with its rising enable set, or a 1-to-0 change with its falling enable set, sets that bit in the status register (address 11). The bit is set no later than the third clock edge after the change. With both enables set, both edges are caught.
- R8: An edge sets no status bit if the bit has no matching enable or if the bit is set as an output.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it. `irqOut` is the OR of all status bits.
- R10: The write-only alias addresses (2, 3, 6, 7, 9, 10) and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| pinIn | input | 32 | Asynchronous input pins |
| pinOut | output | 32 | Output levels |
| pinDirOut | output | 32 | Per-bit direction, 1 = output |
| irqOut | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench checks the alias writes for bits written as 0. A design that treated an alias as a plain write would wipe out every neighbouring bit. It holds a pin in each new level for several cycles and then compares the status register with a model of rising, falling and both-edge detection. A design that swapped the edge polarity or ignored one of the enables would flag the wrong bits. Edges on bits set as outputs, and edges on bits with no enable, must leave the status unchanged. The bench also writes 0 bits to the status register and reads the write-only addresses, which catches a status bit that clears too eagerly and an alias that leaks register contents onto the read bus.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR     = 4'd0,
    A_OUT     = 4'd1,
    A_OUTSET  = 4'd2,
    A_OUTCLR  = 4'd3,
    A_LEVEL   = 4'd4,
    A_RISE    = 4'd5,
    A_RISESET = 4'd6,
    A_RISECLR = 4'd7,
    A_FALL    = 4'd8,
    A_FALLSET = 4'd9,
    A_FALLCLR = 4'd10,
    A_STAT    = 4'd11
  } regSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic wrRise;
    logic setRise;
    logic clrRise;
    logic wrFall;
    logic setFall;
    logic clrFall;
    logic clrStat;
  } strobes_t;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          st,
  output regSel_e           rdSel
);
  regSel_e sel;

  assign sel   = regSel_e'(addr);
  assign rdSel = sel;

  always_comb begin
    st = '0;
    if (wrEn) begin
      unique case (sel)
        A_DIR:     st.wrDir   = 1'b1;
        A_OUT:     st.wrOut   = 1'b1;
        A_OUTSET:  st.setOut  = 1'b1;
        A_OUTCLR:  st.clrOut  = 1'b1;
        A_RISE:    st.wrRise  = 1'b1;
        A_RISESET: st.setRise = 1'b1;
        A_RISECLR: st.clrRise = 1'b1;
        A_FALL:    st.wrFall  = 1'b1;
        A_FALLSET: st.setFall = 1'b1;
        A_FALLCLR: st.clrFall = 1'b1;
        A_STAT:    st.clrStat = 1'b1;
        default:   st = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [WIDTH-1:0] wdata,
  input  regSel_e          rdSel,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinDirOut,
  output logic             irq
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] dirQ, outQ, riseQ, fallQ, statQ;
  logic [WIDTH-1:0] sync1Q, sync2Q, prevQ;
  logic [WIDTH-1:0] hit;

  // A plain write loads; otherwise set bits then clear bits, so clear wins.
  function automatic logic [WIDTH-1:0] applyMask(
    input logic [WIDTH-1:0] cur,
    input logic             wr,
    input logic             set,
    input logic             clr,
    input logic [WIDTH-1:0] d
  );
    logic [WIDTH-1:0] nxt;
    nxt = wr ? d : cur;
    if (set) nxt = nxt | d;
    if (clr) nxt = nxt & ~d;
    return nxt;
  endfunction

  // Per-bit edge qualification, only for bits set as inputs.
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign hit[i] = ~dirQ[i] &
                    ((riseQ[i] &  sync2Q[i] & ~prevQ[i]) |
                     (fallQ[i] & ~sync2Q[i] &  prevQ[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      outQ   <= '0;
      riseQ  <= '0;
      fallQ  <= '0;
      statQ  <= '0;
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      dirQ   <= st.wrDir ? wdata : dirQ;
      outQ   <= applyMask(outQ,  st.wrOut,  st.setOut,  st.clrOut,  wdata);
      riseQ  <= applyMask(riseQ, st.wrRise, st.setRise, st.clrRise, wdata);
      fallQ  <= applyMask(fallQ, st.wrFall, st.setFall, st.clrFall, wdata);
      // A new edge survives a clear write in the same cycle.
      statQ  <= (statQ & ~(st.clrStat ? wdata : ZERO)) | hit;
      sync1Q <= pinIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  always_comb begin
    unique case (rdSel)
      A_DIR:   rdata = dirQ;
      A_OUT:   rdata = outQ;
      A_LEVEL: rdata = sync2Q;
      A_RISE:  rdata = riseQ;
      A_FALL:  rdata = fallQ;
      A_STAT:  rdata = statQ;
      default: rdata = '0;
    endcase
  end

  assign pinOut    = outQ;
  assign pinDirOut = dirQ;
  assign irq       = |statQ;

  AST_RESET_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (dirQ == '0) && (statQ == '0)); // R1

  AST_OUT_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    st.clrOut |=> ((outQ & ~$past(wdata)) == ($past(outQ) & ~$past(wdata)))
                  && ((outQ & $past(wdata)) == '0)); // R3

  AST_RISE_SET: assert property (@(posedge clk) disable iff (!rstN)
    st.setRise |=> ((riseQ & $past(wdata)) == $past(wdata))
                   && ((riseQ & ~$past(wdata)) == ($past(riseQ) & ~$past(wdata)))); // R5

  AST_FALL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    st.clrFall |=> ((fallQ & $past(wdata)) == '0)
                   && ((fallQ & ~$past(wdata)) == ($past(fallQ) & ~$past(wdata)))); // R6

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (hit != '0) |=> ((statQ & $past(hit)) == $past(hit))); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !st.clrStat |=> ((statQ & $past(statQ)) == $past(statQ))); // R9
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinDirOut,
  output logic              irqOut
);
  strobes_t st;
  regSel_e  rdSel;

  gpio_edge_ctrl u_ctrl (
    .wrEn  (regWrEn),
    .addr  (regAddr),
    .st    (st),
    .rdSel (rdSel)
  );

  gpio_edge_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wdata     (regWdata),
    .rdSel     (rdSel),
    .pinIn     (pinIn),
    .rdata     (regRdata),
    .pinOut    (pinOut),
    .pinDirOut (pinDirOut),
    .irq       (irqOut)
  );
endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut, pinDirOut;
  logic         irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] mDir = '0, mOut = '0, mRise = '0, mFall = '0, mStat = '0, mPin = '0;

  always #2 clk = ~clk;

  gpio_edge_irq #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDirOut(pinDirOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [W-1:0] exp);
    logic [W-1:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // Model of one register write.
  function automatic void modelWr(input logic [3:0] a, input logic [W-1:0] d);
    case (a)
      4'd0:  mDir  = d;
      4'd1:  mOut  = d;
      4'd2:  mOut  = mOut | d;
      4'd3:  mOut  = mOut & ~d;
      4'd5:  mRise = d;
      4'd6:  mRise = mRise | d;
      4'd7:  mRise = mRise & ~d;
      4'd8:  mFall = d;
      4'd9:  mFall = mFall | d;
      4'd10: mFall = mFall & ~d;
      4'd11: mStat = mStat & ~d;
      default: ;
    endcase
  endfunction

  function automatic logic [W-1:0] edgeHits(input logic [W-1:0] oldP, input logic [W-1:0] newP);
    return ~mDir & ((mRise & newP & ~oldP) | (mFall & ~newP & oldP));
  endfunction

  task automatic doWr(input logic [3:0] a, input logic [W-1:0] d);
    wr(a, d);
    modelWr(a, d);
  endtask

  task automatic drivePins(input logic [W-1:0] p);
    @(negedge clk);
    mStat = mStat | edgeHits(mPin, p);
    mPin  = p;
    pinIn = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    rdChk({tag, " R2 dir"}, 4'd0, mDir);
    rdChk({tag, " R2 out"}, 4'd1, mOut);
    rdChk({tag, " R5 rise"}, 4'd5, mRise);
    rdChk({tag, " R6 fall"}, 4'd8, mFall);
    rdChk({tag, " R7 status"}, 4'd11, mStat);
    rdChk({tag, " R4 level"}, 4'd4, mPin);
    chk({tag, " R2 pinOut"}, pinOut, mOut);
    chk({tag, " R2 pinDir"}, pinDirOut, mDir);
    chk({tag, " R9 irq"}, {{(W-1){1'b0}}, irqOut}, {{(W-1){1'b0}}, |mStat});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 dir", 4'd0, '0);
    rdChk("R1 out", 4'd1, '0);
    rdChk("R1 rise", 4'd5, '0);
    rdChk("R1 fall", 4'd8, '0);
    rdChk("R1 status", 4'd11, '0);
    chk("R1 pinDirOut", pinDirOut, '0);
    chk("R1 irq", {31'd0, irqOut}, '0);

    // R2 plain writes
    doWr(4'd0, 32'h0000_FF00);
    doWr(4'd1, 32'hA5A5_0F0F);
    checkAll("directed");

    // R3 output aliases leave 0-bits alone
    doWr(4'd2, 32'h0000_00F0);
    rdChk("R3 set", 4'd1, 32'hA5A5_0FFF);
    doWr(4'd3, 32'hA000_0001);
    rdChk("R3 clr", 4'd1, 32'h05A5_0FFE);
    chk("R3 pinOut", pinOut, 32'h05A5_0FFE);

    // R5/R6 enable aliases
    doWr(4'd5, 32'h0000_000F);
    doWr(4'd6, 32'h0000_0030);
    rdChk("R5 set", 4'd5, 32'h0000_003F);
    doWr(4'd7, 32'h0000_0005);
    rdChk("R5 clr", 4'd5, 32'h0000_003A);
    doWr(4'd9, 32'h0000_00C2);
    doWr(4'd10, 32'h0000_0040);
    rdChk("R6 set/clr", 4'd8, 32'h0000_0082);

    // R10 aliases and unmapped addresses read 0
    rdChk("R10 a2", 4'd2, '0);
    rdChk("R10 a7", 4'd7, '0);
    rdChk("R10 a10", 4'd10, '0);
    rdChk("R10 a14", 4'd14, '0);

    // R7 edges: bit1 both enables, bit3 rise only, bit7 fall only
    drivePins(32'h0000_008A);
    rdChk("R7 rising", 4'd11, 32'h0000_000A);
    drivePins(32'h0000_0000);
    rdChk("R7 falling", 4'd11, 32'h0000_008A);
    chk("R9 irq set", {31'd0, irqOut}, 32'd1);

    // R9 writing 0 leaves, writing 1 clears
    doWr(4'd11, 32'h0000_0000);
    rdChk("R9 zero write", 4'd11, 32'h0000_008A);
    doWr(4'd11, 32'h0000_0082);
    rdChk("R9 w1c", 4'd11, 32'h0000_0008);
    doWr(4'd11, 32'h0000_0008);
    chk("R9 irq low", {31'd0, irqOut}, '0);

    // R8 output bit and unenabled bit flag nothing
    doWr(4'd0, 32'h0000_0002);
    drivePins(32'h0001_0002);
    rdChk("R8 no flag", 4'd11, '0);
    drivePins(32'h0000_0000);
    rdChk("R8 no flag fall", 4'd11, '0);

    // Random phase with model
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 12));
      d  = $urandom;
      if (op == 12) drivePins($urandom);
      else doWr(op[3:0], d);
      if (i % 10 == 0) checkAll("random");
    end
    checkAll("final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule